// File: doc/BRIEF.md
# Key-Unlocked Configuration Port

This block is the configuration front end of a multi-function peripheral controller. It sits behind a two-address bus slave: the even address is an index port and the odd address is a data port. After reset the port is locked. Software opens it by writing the key byte 0x55 twice in a row to the index port, and closes it by writing 0xAA to the same port.

While open, an index write selects a register and data-port accesses reach it. Indices below 0x30 select a bank of global registers. Higher indices select a per-device bank, and global register 0x07 names the logical device whose bank is used. Writes pass through filters that depend on the register, the written value and the device number. The block also returns a fixed chip identifier and loads defined reset values. Reads have no side effects and are combinational from the address and the stored state.

Top module: `keycfg_port`

## Requirements
- R1: After reset the port is locked and the key count is cleared. While locked, a read of either address returns 0xFF. A single 0x55 written before a reset does not count towards the key after that reset.
- R2: Two index-port writes of 0x55 in a row while locked unlock the port. The index is not changed by writes made while locked; after reset it is 0x00.
- R3: While locked, an index write of any value other than 0x55 clears the key count. For example, 0x55, 0x12, 0x55 leaves the port locked.
- R4: While unlocked, an index write of 0xAA locks the port again. Data writes made afterwards are ignored.
- R5: While unlocked, an index write of any other value sets the current index, and a read of address 0 returns it.
- R6: Global registers at indices below 0x30 are read and written through the data port. Index 0x20 always reads as the chip identifier parameter CHIP_ID (default 0x40).
- R7: A data write to a global register is ignored when the written value is 0x20 or 0x21.
- R8: After any write, global register 0x03 keeps only bits 7, 1 and 0; the other bits read as 0.
- R9: Global reset values: 0x03 holds 0x03, 0x22 holds 0x39, 0x24 holds 0x04, 0x26 holds 0xF0 and 0x27 holds 0x03. All others hold 0x00.
- R10: Indices 0x30 to 0xFF address the bank of the device numbered in global register 0x07. The base address pair at 0x60/0x61 resets to 0x03/0xF0 for device 0, 0x03/0x78 for device 3, 0x03/0xF8 for device 4 and 0x02/0xF8 for device 5. Other bank bytes reset to 0x00.
- R11: Per-device writes are dropped for devices 1, 2 and 7 and for any device above 0x0A. Devices above 0x0A read as 0xFF.
- R12: Per-device writes to indices 0x70 to 0x7F are dropped for devices 0 to 3 and accepted for devices 4 and up.
- R13: While locked, data-port writes change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe, one cycle per write |
| addr_i | input | 1 | 0 selects the index port, 1 selects the data port |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the port selected by addr_i |

## Verification
The hardest state to reach is the key counter half-armed at the moment something else happens: a foreign index byte, a reset, or a second key. None of these can be seen directly at the ports. The bench reaches each one with a short index-write sequence and then reads 0xFF or real data to show whether the port opened. The drop filters are checked by writing to a blocked device or index and then using a legal device select to read the target byte back.

// File: rtl/keycfg_pkg.sv
package keycfg_pkg;
  localparam int DW = 8;
  localparam logic [DW-1:0] KEY_OPEN  = 8'h55;
  localparam logic [DW-1:0] KEY_CLOSE = 8'hAA;
  localparam logic [DW-1:0] IDX_CHIPID = 8'h20;
  localparam logic [DW-1:0] IDX_GPSEL  = 8'h03;
  localparam logic [DW-1:0] IDX_DEVSEL = 8'h07;
  localparam logic [DW-1:0] GPSEL_MASK = 8'h83;

  function automatic logic [DW-1:0] glb_rst(input int idx);
    case (idx)
      'h03: glb_rst = 8'h03;
      'h22: glb_rst = 8'h39;
      'h24: glb_rst = 8'h04;
      'h26: glb_rst = 8'hF0;
      'h27: glb_rst = 8'h03;
      default: glb_rst = 8'h00;
    endcase
  endfunction

  function automatic logic [DW-1:0] dev_rst(input int dev, input int idx);
    dev_rst = 8'h00;
    if (idx == 'h60) begin
      case (dev)
        0, 3, 4: dev_rst = 8'h03;
        5:       dev_rst = 8'h02;
        default: dev_rst = 8'h00;
      endcase
    end else if (idx == 'h61) begin
      case (dev)
        0:       dev_rst = 8'hF0;
        3:       dev_rst = 8'h78;
        4, 5:    dev_rst = 8'hF8;
        default: dev_rst = 8'h00;
      endcase
    end
  endfunction

  // devices with no writable bank, and the interrupt window for low devices
  function automatic logic dev_writable(input int dev, input logic [DW-1:0] idx);
    logic ok;
    ok = !(dev == 1 || dev == 2 || dev == 7);
    if (idx[7:4] == 4'h7 && dev < 4) ok = 1'b0;
    dev_writable = ok;
  endfunction
endpackage

// File: rtl/keycfg_key_fsm.sv
module keycfg_key_fsm
  import keycfg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          idx_wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          unlocked_o,
  output logic          key_armed_o,
  output logic [DW-1:0] cur_idx_o
);
  logic          unlocked_q, armed_q;
  logic [DW-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unlocked_q <= 1'b0;
      armed_q    <= 1'b0;
      idx_q      <= '0;
    end else if (idx_wr_i) begin
      if (!unlocked_q) begin
        if (wdata_i == KEY_OPEN) begin
          if (armed_q) begin
            unlocked_q <= 1'b1;
            armed_q    <= 1'b0;
          end else begin
            armed_q <= 1'b1;
          end
        end else begin
          armed_q <= 1'b0;
        end
      end else if (wdata_i == KEY_CLOSE) begin
        unlocked_q <= 1'b0;
      end else begin
        idx_q <= wdata_i;
      end
    end
  end

  assign unlocked_o  = unlocked_q;
  assign key_armed_o = armed_q;
  assign cur_idx_o   = idx_q;
endmodule

// File: rtl/keycfg_glb_bank.sv
module keycfg_glb_bank
  import keycfg_pkg::*;
#(
  parameter int GLB_DEPTH = 48,
  parameter logic [7:0] CHIP_ID = 8'h40
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] idx_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] dev_num_o
);
  localparam int AW = $clog2(GLB_DEPTH);

  logic [DW-1:0] regs_q [GLB_DEPTH];
  logic [AW-1:0] addr;
  logic          val_ok;

  assign addr   = idx_i[AW-1:0];
  assign val_ok = !(wdata_i == 8'h20 || wdata_i == 8'h21);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < GLB_DEPTH; i++) regs_q[i] <= glb_rst(i);
    end else if (wr_en_i && val_ok) begin
      if (idx_i == IDX_GPSEL) regs_q[addr] <= wdata_i & GPSEL_MASK;
      else                    regs_q[addr] <= wdata_i;
    end
  end

  assign rdata_o   = (idx_i == IDX_CHIPID) ? CHIP_ID : regs_q[addr];
  assign dev_num_o = regs_q[IDX_DEVSEL[AW-1:0]];
endmodule

// File: rtl/keycfg_dev_bank.sv
module keycfg_dev_bank
  import keycfg_pkg::*;
#(
  parameter int NUM_DEV   = 11,
  parameter int GLB_DEPTH = 48
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] dev_num_i,
  input  logic [DW-1:0] idx_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEV_DEPTH = 256 - GLB_DEPTH;
  localparam int OW = $clog2(DEV_DEPTH);

  logic [DW-1:0] off_full;
  logic [OW-1:0] off;
  logic [DW-1:0] dev_rd [NUM_DEV];

  assign off_full = idx_i - DW'(GLB_DEPTH);
  assign off      = off_full[OW-1:0];

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    logic [DW-1:0] mem_q [DEV_DEPTH];
    logic          we;
    assign we = wr_en_i && (dev_num_i == DW'(d)) && dev_writable(d, idx_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < DEV_DEPTH; i++) mem_q[i] <= dev_rst(d, GLB_DEPTH + i);
      end else if (we) begin
        mem_q[off] <= wdata_i;
      end
    end

    assign dev_rd[d] = mem_q[off];
  end

  always_comb begin
    rdata_o = 8'hFF;
    for (int d = 0; d < NUM_DEV; d++)
      if (dev_num_i == DW'(d)) rdata_o = dev_rd[d];
  end
endmodule

// File: rtl/keycfg_port.sv
module keycfg_port
  import keycfg_pkg::*;
#(
  parameter int NUM_DEV   = 11,
  parameter int GLB_DEPTH = 48,
  parameter logic [7:0] CHIP_ID = 8'h40
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic       addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o
);
  logic          unlocked, key_armed;
  logic [DW-1:0] cur_idx, glb_rd, dev_rd, dev_num;
  logic          is_glb, data_wr;

  assign is_glb  = cur_idx < DW'(GLB_DEPTH);
  assign data_wr = wr_i && addr_i && unlocked;

  keycfg_key_fsm u_key (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .idx_wr_i    (wr_i && !addr_i),
    .wdata_i     (wdata_i),
    .unlocked_o  (unlocked),
    .key_armed_o (key_armed),
    .cur_idx_o   (cur_idx)
  );

  keycfg_glb_bank #(.GLB_DEPTH(GLB_DEPTH), .CHIP_ID(CHIP_ID)) u_glb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (data_wr && is_glb),
    .idx_i     (cur_idx),
    .wdata_i   (wdata_i),
    .rdata_o   (glb_rd),
    .dev_num_o (dev_num)
  );

  keycfg_dev_bank #(.NUM_DEV(NUM_DEV), .GLB_DEPTH(GLB_DEPTH)) u_dev (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (data_wr && !is_glb),
    .dev_num_i (dev_num),
    .idx_i     (cur_idx),
    .wdata_i   (wdata_i),
    .rdata_o   (dev_rd)
  );

  always_comb begin
    if (!unlocked)    rdata_o = 8'hFF;
    else if (!addr_i) rdata_o = cur_idx;
    else if (is_glb)  rdata_o = glb_rd;
    else              rdata_o = dev_rd;
  end
endmodule

// File: rtl/keycfg_port_chk.sv
module keycfg_port_chk #(
  parameter logic [7:0] CHIP_ID = 8'h40
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_i,
  input logic       addr_i,
  input logic [7:0] wdata_i,
  input logic [7:0] rdata_o,
  input logic       unlocked,
  input logic       key_armed,
  input logic [7:0] cur_idx
);
  assert_locked_ff_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unlocked |-> rdata_o == 8'hFF);

  assert_key_open_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!unlocked && key_armed && wr_i && !addr_i && wdata_i == 8'h55) |=> unlocked);

  assert_key_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!unlocked && wr_i && !addr_i && wdata_i != 8'h55) |=> (!key_armed && !unlocked));

  assert_key_close_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unlocked && wr_i && !addr_i && wdata_i == 8'hAA) |=> !unlocked);

  assert_idx_read_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unlocked && !addr_i) |-> rdata_o == cur_idx);

  assert_chip_id_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unlocked && addr_i && cur_idx == 8'h20) |-> rdata_o == CHIP_ID);

  assert_gpsel_mask_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unlocked && addr_i && cur_idx == 8'h03) |-> (rdata_o & 8'h7C) == 8'h00);

  assert_locked_idx_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!unlocked && wr_i) |=> $stable(cur_idx));
endmodule

bind keycfg_port keycfg_port_chk #(.CHIP_ID(CHIP_ID)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_i      (wr_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .unlocked  (unlocked),
  .key_armed (key_armed),
  .cur_idx   (cur_idx)
);

// File: tb/keycfg_port_bench.sv
module keycfg_port_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  keycfg_port u_keycfg_port (
    .clk_i (clk), .rst_ni (rst_n), .wr_i (wr),
    .addr_i (addr), .wdata_i (wdata), .rdata_o (rdata)
  );

  task automatic wr_port(input logic a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_check(input logic a, input logic [7:0] exp, input string req);
    @(negedge clk); addr = a; #1;
    n_chk++;
    if (rdata !== exp) begin
      n_err++;
      $display("FAIL %s: addr=%0d got %02h expected %02h", req, a, rdata, exp);
    end
  endtask

  task automatic set_idx(input logic [7:0] i); wr_port(1'b0, i); endtask
  task automatic unlock(); wr_port(1'b0, 8'h55); wr_port(1'b0, 8'h55); endtask
  task automatic reg_rd(input logic [7:0] i, input logic [7:0] exp, input string req);
    set_idx(i); rd_check(1'b1, exp, req);
  endtask
  task automatic reg_wr(input logic [7:0] i, input logic [7:0] d);
    set_idx(i); wr_port(1'b1, d);
  endtask
  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; #3; rst_n = 1'b1;
  endtask

  task automatic t_reset_r1();
    rd_check(1'b0, 8'hFF, "R1");
    rd_check(1'b1, 8'hFF, "R1");
  endtask

  task automatic t_key_r3_r2_r13();
    wr_port(1'b1, 8'h5A);            // locked data write to index 0
    wr_port(1'b0, 8'h55); wr_port(1'b0, 8'h12); wr_port(1'b0, 8'h55);
    rd_check(1'b1, 8'hFF, "R3");
    wr_port(1'b0, 8'h55);
    rd_check(1'b0, 8'h00, "R2");
    rd_check(1'b1, 8'h00, "R13");
  endtask

  task automatic t_global_r5_r9();
    set_idx(8'h24); rd_check(1'b0, 8'h24, "R5");
    rd_check(1'b1, 8'h04, "R9");
    reg_rd(8'h03, 8'h03, "R9");
    reg_rd(8'h22, 8'h39, "R9");
    reg_rd(8'h26, 8'hF0, "R9");
    reg_rd(8'h27, 8'h03, "R9");
    reg_rd(8'h11, 8'h00, "R9");
  endtask

  task automatic t_global_r6_r7_r8();
    reg_wr(8'h10, 8'h5C); reg_rd(8'h10, 8'h5C, "R6");
    reg_rd(8'h20, 8'h40, "R6");
    reg_wr(8'h20, 8'h99); reg_rd(8'h20, 8'h40, "R6");
    reg_wr(8'h10, 8'h21); reg_rd(8'h10, 8'h5C, "R7");
    reg_wr(8'h10, 8'h20); reg_rd(8'h10, 8'h5C, "R7");
    reg_wr(8'h03, 8'hFF); reg_rd(8'h03, 8'h83, "R8");
  endtask

  task automatic t_dev_r10();
    reg_wr(8'h07, 8'h00); reg_rd(8'h60, 8'h03, "R10"); reg_rd(8'h61, 8'hF0, "R10");
    reg_wr(8'h07, 8'h03); reg_rd(8'h60, 8'h03, "R10"); reg_rd(8'h61, 8'h78, "R10");
    reg_wr(8'h07, 8'h04); reg_rd(8'h60, 8'h03, "R10"); reg_rd(8'h61, 8'hF8, "R10");
    reg_wr(8'h07, 8'h05); reg_rd(8'h60, 8'h02, "R10"); reg_rd(8'h61, 8'hF8, "R10");
    reg_wr(8'h07, 8'h04); reg_wr(8'h60, 8'h02); reg_rd(8'h60, 8'h02, "R10");
  endtask

  task automatic t_dev_r11_r12();
    reg_wr(8'h07, 8'h02); reg_wr(8'h60, 8'h12); reg_rd(8'h60, 8'h00, "R11");
    reg_wr(8'h07, 8'h07); reg_wr(8'hF0, 8'h33); reg_rd(8'hF0, 8'h00, "R11");
    reg_wr(8'h07, 8'h01); reg_wr(8'hF0, 8'h33); reg_rd(8'hF0, 8'h00, "R11");
    reg_wr(8'h07, 8'h06); reg_wr(8'hF0, 8'h33); reg_rd(8'hF0, 8'h33, "R11");
    reg_wr(8'h07, 8'h0A); reg_wr(8'hF0, 8'h44); reg_rd(8'hF0, 8'h44, "R11");
    reg_wr(8'h07, 8'h0B); reg_wr(8'hF0, 8'h44); reg_rd(8'hF0, 8'hFF, "R11");
    reg_wr(8'h07, 8'h00); reg_wr(8'h70, 8'h09); reg_rd(8'h70, 8'h00, "R12");
    reg_wr(8'h07, 8'h03); reg_wr(8'h7F, 8'h09); reg_rd(8'h7F, 8'h00, "R12");
    reg_wr(8'h07, 8'h04); reg_wr(8'h70, 8'h09); reg_rd(8'h70, 8'h09, "R12");
  endtask

  task automatic t_exit_r4();
    reg_wr(8'h07, 8'h06); set_idx(8'hF0);
    wr_port(1'b0, 8'hAA);
    rd_check(1'b0, 8'hFF, "R4");
    rd_check(1'b1, 8'hFF, "R4");
    wr_port(1'b1, 8'h77);
    unlock();
    rd_check(1'b0, 8'hF0, "R4");
    rd_check(1'b1, 8'h33, "R4");
  endtask

  task automatic t_reset_key_r1();
    wr_port(1'b0, 8'hAA);
    wr_port(1'b0, 8'h55);
    do_reset();
    wr_port(1'b0, 8'h55);
    rd_check(1'b1, 8'hFF, "R1");
    wr_port(1'b0, 8'h55);
    rd_check(1'b0, 8'h00, "R1");
    reg_rd(8'h10, 8'h00, "R1");
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_reset_r1();
    t_key_r3_r2_r13();
    t_global_r5_r9();
    t_global_r6_r7_r8();
    t_dev_r10();
    t_dev_r11_r12();
    t_exit_r4();
    t_reset_key_r1();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule